// File: doc/BRIEF.md
# Pipelined Processor Bus Cycle Sequencer

This block is the bus-master sequencer of a 32-bit processor. It takes transfer requests from the core one at a time and runs each one as an external read or write bus cycle. For each cycle it drives an active-low address strobe, a word address, active-low byte enables and three cycle-definition lines. It then waits for an active-low transfer-acknowledge. Each clock period is one bus state. A cycle lasts at least two states, and the sequencer adds wait states for as long as acknowledge stays inactive.

Address timing is chosen for each cycle separately. By default the address and definition stay on the bus for the whole cycle. If the active-low next-address input is seen asserted at a legal sampling point while another request is waiting, the sequencer grants that request and issues its address and strobe in the very next state. The current cycle may still be unacknowledged at that point. The issued cycle then becomes the current one as soon as the earlier cycle is acknowledged.

On the request side, `reqValid` is held with its fields until `reqGrant` pulses for one cycle. Read data comes back on `rdData` with a one-cycle `rdDone` pulse.

Top module: `busCycleSeq`

## Requirements
- R1: While reset is asserted and after it is released with no request, `busAdsN` is 1, `busDataOe` is 0, `rdDone` is 0 and `reqGrant` is 0.
- R2: `reqGrant` is a one-cycle pulse. It is given only while `reqValid` is 1 and the sequencer is idle, acknowledging a cycle, or issuing a pipelined address. It is never given in the state in which a strobe is driven.
- R3: `busAdsN` is 0 for exactly one state per cycle, in the state after the grant. In that state `busAddr`, `busBeN` (the inverse of `reqByteEn`), `busWr`, `busDc` and `busMio` equal the granted request's fields.
- R4: Acknowledge is first sampled in the second state of a cycle. A cycle with `busReadyN` 0 in that state lasts exactly two states.
- R5: While `busReadyN` is 1 the cycle continues without limit. In a non-pipelined cycle the address, byte enables and definition do not change until the cycle ends.
- R6: In a non-pipelined cycle, `busNaN` is ignored in the second state. It is sampled only in wait states, and there a 0 with a pending request gives a grant.
- R7: After a pipelined grant, the next state drives `busAdsN` 0 with the new address and definition while the current cycle is unacknowledged. Any write data of the current cycle stays driven.
- R8: In a cycle whose address was issued early, `busNaN` is sampled already in that cycle's first data state.
- R9: Acknowledge with no pending request returns the sequencer to idle. A cycle started from idle, or started directly after an acknowledge, is non-pipelined.
- R10: For a write, `busDataOe` is 1 with `busDataOut` equal to the write data from the state after the strobe through the acknowledging state, and 0 otherwise.
- R11: Read data on `busDataIn` in the acknowledging state appears on `rdData`, with `rdDone` 1 for exactly one cycle in the following cycle.
- R12: An acknowledge in the early-address state ends the current cycle. The next state is the data state of the early-issued cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bus state per period |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Core has a transfer request |
| reqAddr | input | 30 | Word address of the request (address bits 31:2) |
| reqByteEn | input | 4 | Active-high byte lanes of the request |
| reqWr | input | 1 | 1 = write, 0 = read |
| reqDc | input | 1 | 1 = data, 0 = code |
| reqMio | input | 1 | 1 = memory, 0 = I/O |
| reqWdata | input | 32 | Write data of the request |
| reqGrant | output | 1 | One-cycle acceptance of the request |
| rdDone | output | 1 | One-cycle pulse: read data valid |
| rdData | output | 32 | Captured read data |
| busAdsN | output | 1 | Active-low address strobe |
| busAddr | output | 30 | Bus word address |
| busBeN | output | 4 | Active-low byte enables |
| busWr | output | 1 | Cycle definition: write/read |
| busDc | output | 1 | Cycle definition: data/code |
| busMio | output | 1 | Cycle definition: memory/IO |
| busDataOut | output | 32 | Write data toward the bus |
| busDataOe | output | 1 | Write data drive enable |
| busDataIn | input | 32 | Read data from the bus |
| busReadyN | input | 1 | Active-low transfer acknowledge |
| busNaN | input | 1 | Active-low next-address request |

## Verification
A wrong sequencer state shows at the ports within one bus state. A state that should issue a strobe but does not gives no `busAdsN` low the cycle after the grant. A strobe state that repeats keeps `busAdsN` low for two states. A wrong wait-state or pipeline flag shows up as a `reqGrant` in a state where `busNaN` must be ignored, or as a missing grant where it must be sampled. A mix-up between the current and the early-issued cycle changes `busDataOe`/`busDataOut` in the overlap states, or misplaces `rdDone` by one state. The directed scenarios therefore compare every output in every state of each cycle.

// File: rtl/busSeqPkg.sv
package busSeqPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_T1,
    ST_T2,
    ST_T1P,
    ST_T2P
  } busState_t;

  // strobes from the sequencer control to the datapath
  typedef struct packed {
    logic loadReq;    // capture request into address and pending registers
    logic promote;    // pending cycle becomes the current data-phase cycle
    logic dataPhase;  // a current cycle is in its data phase
    logic ack;        // current cycle acknowledged in this state
  } seqCtl_t;

endpackage

// File: rtl/busSeqCtrl.sv
module busSeqCtrl
  import busSeqPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    busReadyN,
  input  logic    busNaN,
  output logic    reqGrant,
  output logic    busAdsN,
  output seqCtl_t ctl
);

  busState_t state, stateNx;
  logic waited, waitedNx;        // current non-pipelined cycle is in a wait state
  logic curPipe, curPipeNx;      // current cycle had its address issued early
  logic naLatched, naLatchedNx;  // next-address seen, no request yet
  logic dataPhase, ack, naOk, naHit;

  assign dataPhase = (state == ST_T2) || (state == ST_T1P) || (state == ST_T2P);
  assign ack       = dataPhase && !busReadyN;
  assign naOk      = waited || curPipe;
  assign naHit     = naLatched || (naOk && !busNaN);

  always_comb begin
    stateNx     = state;
    waitedNx    = waited;
    curPipeNx   = curPipe;
    naLatchedNx = naLatched;
    reqGrant    = 1'b0;
    ctl.promote = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          reqGrant = 1'b1;
          stateNx  = ST_T1;
        end
      end
      ST_T1: begin
        ctl.promote = 1'b1;
        stateNx     = ST_T2;
        waitedNx    = 1'b0;
        curPipeNx   = 1'b0;
        naLatchedNx = 1'b0;
      end
      ST_T2: begin
        if (ack) begin
          naLatchedNx = 1'b0;
          if (reqValid) begin
            reqGrant = 1'b1;
            stateNx  = ST_T1;
          end else begin
            stateNx = ST_IDLE;
          end
        end else if (naHit && reqValid) begin
          reqGrant    = 1'b1;
          naLatchedNx = 1'b0;
          stateNx     = ST_T1P;
        end else begin
          waitedNx    = 1'b1;
          naLatchedNx = naHit;
        end
      end
      ST_T1P, ST_T2P: begin
        if (ack) begin
          ctl.promote = 1'b1;
          stateNx     = ST_T2;
          curPipeNx   = 1'b1;
          waitedNx    = 1'b0;
        end else begin
          stateNx = ST_T2P;
        end
      end
      default: stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      waited    <= 1'b0;
      curPipe   <= 1'b0;
      naLatched <= 1'b0;
    end else begin
      state     <= stateNx;
      waited    <= waitedNx;
      curPipe   <= curPipeNx;
      naLatched <= naLatchedNx;
    end
  end

  assign busAdsN       = !((state == ST_T1) || (state == ST_T1P));
  assign ctl.loadReq   = reqGrant;
  assign ctl.dataPhase = dataPhase;
  assign ctl.ack       = ack;

  AST_ADS_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_T1) || (state == ST_T1P)) |=> !((state == ST_T1) || (state == ST_T1P))); // R3
  AST_SECOND_STATE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_T1) |=> (state == ST_T2)); // R4
  AST_IDLE_NONPIPE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |=> ((state == ST_IDLE) || (state == ST_T1))); // R9
  AST_EARLY_FROM_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_T1P) |-> ($past(state) == ST_T2)); // R7
  AST_GRANT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    reqGrant |=> !reqGrant); // R2

endmodule

// File: rtl/busSeqPath.sv
module busSeqPath
  import busSeqPkg::*;
#(
  parameter int ADDR_W = 30,
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [BE_W-1:0]   reqByteEn,
  input  logic              reqWr,
  input  logic              reqDc,
  input  logic              reqMio,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busDataIn,
  output logic [ADDR_W-1:0] busAddr,
  output logic [BE_W-1:0]   busBeN,
  output logic              busWr,
  output logic              busDc,
  output logic              busMio,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  output logic              rdDone,
  output logic [DATA_W-1:0] rdData
);

  // address-side registers: follow the most recently granted request
  logic [ADDR_W-1:0] aAddr;
  logic [BE_W-1:0]   aBe;
  logic              aWr, aDc, aMio;
  // pending (granted, not yet in data phase) and current data-phase cycles
  logic              pWr, cWr;
  logic [DATA_W-1:0] pData, cData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aAddr  <= '0;
      aBe    <= '0;
      aWr    <= 1'b0;
      aDc    <= 1'b0;
      aMio   <= 1'b0;
      pWr    <= 1'b0;
      pData  <= '0;
      cWr    <= 1'b0;
      cData  <= '0;
      rdDone <= 1'b0;
      rdData <= '0;
    end else begin
      if (ctl.loadReq) begin
        aAddr <= reqAddr;
        aBe   <= reqByteEn;
        aWr   <= reqWr;
        aDc   <= reqDc;
        aMio  <= reqMio;
        pWr   <= reqWr;
        pData <= reqWdata;
      end
      if (ctl.promote) begin
        cWr   <= pWr;
        cData <= pData;
      end
      rdDone <= ctl.ack && !cWr;
      if (ctl.ack && !cWr) rdData <= busDataIn;
    end
  end

  for (genvar lane = 0; lane < BE_W; lane++) begin : g_lane
    assign busBeN[lane] = ~aBe[lane];
  end

  assign busAddr    = aAddr;
  assign busWr      = aWr;
  assign busDc      = aDc;
  assign busMio     = aMio;
  assign busDataOut = cData;
  assign busDataOe  = ctl.dataPhase && cWr;

  AST_ADDR_FROM_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadReq |=> (busAddr == $past(reqAddr)) && (busWr == $past(reqWr))); // R3

endmodule

// File: rtl/busCycleSeq.sv
module busCycleSeq
  import busSeqPkg::*;
#(
  parameter int ADDR_W = 30,
  parameter int DATA_W = 32,
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [BE_W-1:0]   reqByteEn,
  input  logic              reqWr,
  input  logic              reqDc,
  input  logic              reqMio,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqGrant,
  output logic              rdDone,
  output logic [DATA_W-1:0] rdData,
  output logic              busAdsN,
  output logic [ADDR_W-1:0] busAddr,
  output logic [BE_W-1:0]   busBeN,
  output logic              busWr,
  output logic              busDc,
  output logic              busMio,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  input  logic [DATA_W-1:0] busDataIn,
  input  logic              busReadyN,
  input  logic              busNaN
);

  seqCtl_t ctl;

  busSeqCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .busReadyN(busReadyN),
    .busNaN   (busNaN),
    .reqGrant (reqGrant),
    .busAdsN  (busAdsN),
    .ctl      (ctl)
  );

  busSeqPath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .reqAddr   (reqAddr),
    .reqByteEn (reqByteEn),
    .reqWr     (reqWr),
    .reqDc     (reqDc),
    .reqMio    (reqMio),
    .reqWdata  (reqWdata),
    .busDataIn (busDataIn),
    .busAddr   (busAddr),
    .busBeN    (busBeN),
    .busWr     (busWr),
    .busDc     (busDc),
    .busMio    (busMio),
    .busDataOut(busDataOut),
    .busDataOe (busDataOe),
    .rdDone    (rdDone),
    .rdData    (rdData)
  );

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(reqGrant) |-> $stable(busAddr) && $stable(busBeN)); // R5
  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    rdDone |-> $past(!busReadyN)); // R11

endmodule

// File: tb/busCycleSeq_test.sv
`timescale 1ns/1ps
module busCycleSeq_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [29:0] reqAddr = '0;
  logic [3:0]  reqByteEn = '0;
  logic        reqWr = 1'b0, reqDc = 1'b0, reqMio = 1'b0;
  logic [31:0] reqWdata = '0;
  logic        reqGrant, rdDone, busAdsN, busWr, busDc, busMio, busDataOe;
  logic [31:0] rdData, busDataOut;
  logic [29:0] busAddr;
  logic [3:0]  busBeN;
  logic [31:0] busDataIn = '0;
  logic        busReadyN = 1'b1, busNaN = 1'b1;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  busCycleSeq uut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic setReq(input logic v, input logic [29:0] a, input logic [3:0] be,
                        input logic wr, input logic dc, input logic mio, input logic [31:0] wd);
    reqValid = v; reqAddr = a; reqByteEn = be; reqWr = wr; reqDc = dc; reqMio = mio; reqWdata = wd;
  endtask

  task automatic step;
    @(negedge clk);
  endtask

  task automatic finishRun;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  task automatic tReset;
    step; #1;
    check("R1 ads in reset", busAdsN, 1);
    check("R1 oe in reset", busDataOe, 0);
    step; rstN = 1'b1; step; #1;
    check("R1 ads idle", busAdsN, 1);
    check("R1 grant idle", reqGrant, 0);
    check("R1 done idle", rdDone, 0);
    check("R1 oe idle", busDataOe, 0);
  endtask

  task automatic tZeroWaitRead;
    step; setReq(1, 30'h0123456, 4'b0011, 0, 1, 1, 0); #1;
    check("R2 grant idle", reqGrant, 1);
    step; reqValid = 0; #1;
    check("R3 ads low", busAdsN, 0);
    check("R3 addr", busAddr, 30'h0123456);
    check("R3 be", busBeN, 4'b1100);
    check("R3 def", {busWr, busDc, busMio}, 3'b011);
    check("R2 no grant in T1", reqGrant, 0);
    step; busReadyN = 0; busDataIn = 32'hCAFE0001; #1;
    check("R3 ads one state", busAdsN, 1);
    check("R10 no oe read", busDataOe, 0);
    step; busReadyN = 1; #1;
    check("R4 two-state cycle done", rdDone, 1);
    check("R11 read data", rdData, 32'hCAFE0001);
    check("R9 idle no ads", busAdsN, 1);
    step; #1;
    check("R11 done pulse", rdDone, 0);
  endtask

  task automatic tWaitWrite;
    step; setReq(1, 30'h2AAAAAA, 4'b1111, 1, 1, 0, 32'h55AA1234); #1;
    check("R2 grant", reqGrant, 1);
    step; reqValid = 0; #1;
    check("R3 ads", busAdsN, 0);
    check("R10 no oe in strobe state", busDataOe, 0);
    step; busReadyN = 1; #1;
    check("R10 oe data state", busDataOe, 1);
    check("R10 write data", busDataOut, 32'h55AA1234);
    for (int w = 0; w < 3; w++) begin
      step; #1;
      check("R5 wait addr stable", busAddr, 30'h2AAAAAA);
      check("R5 wait def stable", {busWr, busDc, busMio, busBeN}, {3'b110, 4'b0000});
      check("R5 no strobe in wait", busAdsN, 1);
      check("R10 oe in wait", busDataOe, 1);
    end
    busReadyN = 0; #1;
    check("R10 oe ack state", busDataOe, 1);
    step; busReadyN = 1; #1;
    check("R10 oe off after ack", busDataOe, 0);
    check("R11 no done on write", rdDone, 0);
  endtask

  task automatic tPipelined;
    step; setReq(1, 30'h0000100, 4'b1111, 1, 1, 1, 32'hA0A0A0A0); #1;
    check("R2 grant A", reqGrant, 1);
    step; setReq(1, 30'h0000200, 4'b0001, 0, 0, 1, 0); busNaN = 0; #1;
    check("R2 no grant in strobe state", reqGrant, 0);
    check("R3 addr A", busAddr, 30'h0000100);
    step; busReadyN = 1; busNaN = 0; #1;
    check("R6 next-address ignored in second state", reqGrant, 0);
    check("R10 oe A", busDataOut, 32'hA0A0A0A0);
    step; #1;
    check("R6 next-address sampled in wait", reqGrant, 1);
    check("R5 addr still A", busAddr, 30'h0000100);
    step; reqValid = 0; busNaN = 1; #1;
    check("R7 early strobe", busAdsN, 0);
    check("R7 early addr", busAddr, 30'h0000200);
    check("R7 early def", {busWr, busDc, busMio, busBeN}, {3'b001, 4'b1110});
    check("R7 current write still driven", {busDataOe, busDataOut}, {1'b1, 32'hA0A0A0A0});
    step; busReadyN = 0; #1;
    check("R7 overlap ads high", busAdsN, 1);
    check("R7 overlap data", {busDataOe, busDataOut}, {1'b1, 32'hA0A0A0A0});
    step; setReq(1, 30'h0000300, 4'b1000, 1, 0, 0, 32'hC3C3C3C3);
    busReadyN = 1; busNaN = 0; #1;
    check("R8 next-address in first data state", reqGrant, 1);
    check("R10 no oe for read", busDataOe, 0);
    step; reqValid = 0; busNaN = 1; busReadyN = 0; busDataIn = 32'hBEEF0B0B; #1;
    check("R7 strobe C", busAdsN, 0);
    check("R7 addr C", busAddr, 30'h0000300);
    step; busReadyN = 0; #1;
    check("R12 read done after early ack", rdDone, 1);
    check("R12 read data", rdData, 32'hBEEF0B0B);
    check("R12 data state of C", {busAdsN, busDataOe, busDataOut}, {1'b1, 1'b1, 32'hC3C3C3C3});
    step; busReadyN = 1; #1;
    check("R9 idle after ack", {busAdsN, busDataOe, reqGrant}, 3'b100);
  endtask

  task automatic tBackToBack;
    step; setReq(1, 30'h0000010, 4'b1111, 0, 1, 1, 0); #1;
    check("R2 grant", reqGrant, 1);
    step; setReq(1, 30'h0000020, 4'b1111, 0, 1, 1, 0); #1;
    check("R3 strobe", busAdsN, 0);
    step; busReadyN = 0; busDataIn = 32'h11112222; #1;
    check("R9 grant at ack", reqGrant, 1);
    step; setReq(1, 30'h0000030, 4'b1111, 0, 1, 1, 0); busReadyN = 1; #1;
    check("R9 new strobe without idle", busAdsN, 0);
    check("R9 addr B", busAddr, 30'h0000020);
    check("R11 data A", {rdDone, rdData}, {1'b1, 32'h11112222});
    step; busNaN = 0; #1;
    check("R9 non-pipelined after ack", reqGrant, 0);
    check("R11 done pulse end", rdDone, 0);
    step; reqValid = 0; busNaN = 1; busReadyN = 0; busDataIn = 32'h33334444; #1;
    check("R5 addr B held", busAddr, 30'h0000020);
    step; busReadyN = 1; #1;
    check("R11 data B", {rdDone, rdData}, {1'b1, 32'h33334444});
    check("R9 idle", busAdsN, 1);
  endtask

  initial begin
    tReset;
    tZeroWaitRead;
    tWaitWrite;
    tPipelined;
    tBackToBack;
    step;
    finishRun;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual %0d expected below 5000 cycles", cycles);
      finishRun;
    end
  end

endmodule